// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps a record of what brought the system out of its last reset, so that boot software can find out why it is running. Each reset source delivers a one-cycle pulse: the external reset pin, the watchdog, the illegal-opcode detector, the illegal-address detector (with a qualifier that marks the access as an opcode fetch), and the low-voltage detector. Each pulse sets its own flag. A separate power-on reset input forces the record to a single fixed pattern. Software reads the record as one read-only status byte at a fixed bus address.

Software reads the status byte and then decides what to do. The read returns the flags and clears them, so the next read shows only the resets that came after it. If software does not read the byte, flags from later resets build up on top of the ones already set. The flag storage holds its value through every reset except power-on, because the block has no other reset input. The bus interface is a plain read strobe with an address and a combinational read value. It has no handshake or back-pressure. Bus writes are not connected: the byte is read-only.

Top module: `rcsr_top`

## Requirements
- R1: While `pwr_on_rst` is high, the status byte is 8'h80: the power-on flag is set and every other flag is clear. This holds even when source pulses arrive in the same cycles.
- R2: The flags sit at these bit positions: power-on in bit 7, external pin in bit 6, watchdog in bit 5, illegal opcode in bit 4, illegal-address fetch in bit 3, low voltage in bit 1.
- R3: A pulse on `src_pin`, `src_wdog`, `src_illop` or `src_lowv` sets its flag, and the flag is visible from the next clock edge.
- R4: A pulse on `src_illadr` sets the illegal-address flag only when `src_illadr_fetch` is high in the same cycle. A pulse without the qualifier changes nothing.
- R5: When `rd_en` is high and `rd_addr` equals REG_ADDR (default 16'hFE01), `rd_data` shows the flags held before the read. All flags are clear from the next clock edge.
- R6: A read at any other address returns 8'h00 and leaves the flags unchanged.
- R7: Until a read clears them, flags set by different sources in different cycles are ORed together.
- R8: If a source pulse arrives in the same cycle as a clearing read, that source's flag is still set after the read.
- R9: Bits 2 and 0 of `rd_data` always read 0.
- R10: `rd_data` is 8'h00 whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_on_rst | input | 1 | Power-on reset, active high, asynchronous; forces the byte to 8'h80 |
| src_pin | input | 1 | Pulse from the external reset pin |
| src_wdog | input | 1 | Pulse from the watchdog reset |
| src_illop | input | 1 | Pulse from the illegal opcode reset |
| src_illadr | input | 1 | Pulse from the illegal address reset |
| src_illadr_fetch | input | 1 | Qualifier: the illegal access was an opcode fetch |
| src_lowv | input | 1 | Pulse from the low-voltage reset |
| rd_en | input | 1 | Bus read strobe |
| rd_addr | input | ADDR_W | Bus read address |
| rd_data | output | 8 | Read value; zero unless the status byte is being read |

## Verification
The checker tests the following on every cycle:
- bits 2 and 0 read 0, and `rd_data` is 0 while no read is in progress;
- a source pulse sets its flag, and without a read, flags are never lost;
- the illegal-address flag moves only when the fetch qualifier is present;
- a clearing read empties the byte, and a read at another address leaves it as it was;
- a source pulse that meets a read still sets its flag.

The bench scenarios show what the checker does not:
- the exact byte values seen by software for each source and for combinations of sources;
- the fixed power-on pattern, including the case where a source pulse arrives during power-on;
- the order in which values appear across a sequence of reads.

// File: rtl/rcsr_pkg.sv
package rcsr_pkg;
  localparam int NUM_SRC = 5;
  localparam int BYTE_W  = 8;
  localparam int POR_BIT = 7;

  // source index order inside the block
  localparam int SRC_PIN    = 0;
  localparam int SRC_WDOG   = 1;
  localparam int SRC_ILLOP  = 2;
  localparam int SRC_ILLADR = 3;
  localparam int SRC_LOWV   = 4;

  // byte position of each source flag (R2)
  function automatic int src_bit(input int idx);
    case (idx)
      SRC_PIN:    return 6;
      SRC_WDOG:   return 5;
      SRC_ILLOP:  return 4;
      SRC_ILLADR: return 3;
      default:    return 1;
    endcase
  endfunction
endpackage

// File: rtl/rcsr_addr_dec.sv
module rcsr_addr_dec #(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] REG_ADDR = 16'hFE01
) (
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(REG_ADDR);

  assign hit = rd_en && (rd_addr == MATCH);
endmodule

// File: rtl/rcsr_src_qual.sv
module rcsr_src_qual
  import rcsr_pkg::*;
(
  input  logic               src_pin,
  input  logic               src_wdog,
  input  logic               src_illop,
  input  logic               src_illadr,
  input  logic               src_illadr_fetch,
  input  logic               src_lowv,
  output logic [NUM_SRC-1:0] set_vec
);
  always_comb begin
    set_vec             = '0;
    set_vec[SRC_PIN]    = src_pin;
    set_vec[SRC_WDOG]   = src_wdog;
    set_vec[SRC_ILLOP]  = src_illop;
    set_vec[SRC_ILLADR] = src_illadr & src_illadr_fetch;  // R4: only opcode fetches count
    set_vec[SRC_LOWV]   = src_lowv;
  end
endmodule

// File: rtl/rcsr_flag_bank.sv
module rcsr_flag_bank
  import rcsr_pkg::*;
(
  input  logic               clk,
  input  logic               pwr_on_rst,
  input  logic [NUM_SRC-1:0] set_vec,
  input  logic               clr,
  output logic               por_flag,
  output logic [NUM_SRC-1:0] src_flags
);
  // power-on flag: forced by power-on, only a read clears it
  always_ff @(posedge clk or posedge pwr_on_rst) begin
    if (pwr_on_rst)  por_flag <= 1'b1;
    else if (clr)    por_flag <= 1'b0;
  end

  // one sticky cell per source; a set beats a same-cycle clear (R8)
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_cell
    always_ff @(posedge clk or posedge pwr_on_rst) begin
      if (pwr_on_rst)      src_flags[i] <= 1'b0;
      else if (set_vec[i]) src_flags[i] <= 1'b1;
      else if (clr)        src_flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/rcsr_rd_mux.sv
module rcsr_rd_mux
  import rcsr_pkg::*;
(
  input  logic               hit,
  input  logic               por_flag,
  input  logic [NUM_SRC-1:0] src_flags,
  output logic [BYTE_W-1:0]  stat_byte,
  output logic [BYTE_W-1:0]  rd_data
);
  always_comb begin
    stat_byte          = '0;
    stat_byte[POR_BIT] = por_flag;
    for (int i = 0; i < NUM_SRC; i++) stat_byte[src_bit(i)] = src_flags[i];
  end

  assign rd_data = hit ? stat_byte : '0;
endmodule

// File: rtl/rcsr_top.sv
module rcsr_top
  import rcsr_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] REG_ADDR = 16'hFE01
) (
  input  logic              clk,
  input  logic              pwr_on_rst,
  input  logic              src_pin,
  input  logic              src_wdog,
  input  logic              src_illop,
  input  logic              src_illadr,
  input  logic              src_illadr_fetch,
  input  logic              src_lowv,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  logic               hit;
  logic [NUM_SRC-1:0] set_vec;
  logic               por_flag;
  logic [NUM_SRC-1:0] src_flags;
  logic [BYTE_W-1:0]  stat_byte;

  rcsr_addr_dec #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_dec (
    .rd_en(rd_en), .rd_addr(rd_addr), .hit(hit)
  );

  rcsr_src_qual u_qual (
    .src_pin(src_pin), .src_wdog(src_wdog), .src_illop(src_illop),
    .src_illadr(src_illadr), .src_illadr_fetch(src_illadr_fetch),
    .src_lowv(src_lowv), .set_vec(set_vec)
  );

  rcsr_flag_bank u_bank (
    .clk(clk), .pwr_on_rst(pwr_on_rst), .set_vec(set_vec), .clr(hit),
    .por_flag(por_flag), .src_flags(src_flags)
  );

  rcsr_rd_mux u_mux (
    .hit(hit), .por_flag(por_flag), .src_flags(src_flags),
    .stat_byte(stat_byte), .rd_data(rd_data)
  );
endmodule

// File: rtl/rcsr_chk.sv
module rcsr_chk #(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] REG_ADDR = 16'hFE01
) (
  input logic              clk,
  input logic              pwr_on_rst,
  input logic              src_pin,
  input logic              src_wdog,
  input logic              src_illop,
  input logic              src_illadr,
  input logic              src_illadr_fetch,
  input logic              src_lowv,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [7:0]        rd_data,
  input logic [7:0]        stat_byte
);
  logic rd_here;
  logic any_src;
  assign rd_here = rd_en && (rd_addr == ADDR_W'(REG_ADDR));
  assign any_src = src_pin | src_wdog | src_illop | src_illadr | src_lowv;

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (pwr_on_rst)
    (rd_data[2] == 1'b0) && (rd_data[0] == 1'b0)); // R9

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (pwr_on_rst)
    !rd_en |-> (rd_data == 8'h00)); // R10

  AST_WDOG_SETS: assert property (@(posedge clk) disable iff (pwr_on_rst)
    src_wdog |=> stat_byte[5]); // R3

  AST_FETCH_QUAL: assert property (@(posedge clk) disable iff (pwr_on_rst)
    (!(src_illadr && src_illadr_fetch) && !rd_here) |=> $stable(stat_byte[3])); // R4

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (pwr_on_rst)
    (rd_here && !any_src) |=> (stat_byte == 8'h00)); // R5

  AST_OTHER_ADDR: assert property (@(posedge clk) disable iff (pwr_on_rst)
    (rd_en && !rd_here && !any_src) |=> $stable(stat_byte)); // R6

  AST_NO_LOSS: assert property (@(posedge clk) disable iff (pwr_on_rst)
    !rd_here |=> ((stat_byte & $past(stat_byte)) == $past(stat_byte))); // R7

  AST_SET_WINS: assert property (@(posedge clk) disable iff (pwr_on_rst)
    (rd_here && src_pin) |=> stat_byte[6]); // R8
endmodule

bind rcsr_top rcsr_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
  .clk(clk), .pwr_on_rst(pwr_on_rst), .src_pin(src_pin), .src_wdog(src_wdog),
  .src_illop(src_illop), .src_illadr(src_illadr),
  .src_illadr_fetch(src_illadr_fetch), .src_lowv(src_lowv), .rd_en(rd_en),
  .rd_addr(rd_addr), .rd_data(rd_data), .stat_byte(stat_byte)
);

// File: tb/rcsr_top_bench.sv
module rcsr_top_bench;
  localparam int ADDR_W = 16;
  localparam logic [15:0] REG_A = 16'hFE01;
  localparam logic [15:0] OTHER_A = 16'hFE02;

  logic clk = 1'b0;
  logic pwr_on_rst = 1'b1;
  logic src_pin = 0, src_wdog = 0, src_illop = 0, src_illadr = 0;
  logic src_illadr_fetch = 0, src_lowv = 0, rd_en = 0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rcsr_top #(.ADDR_W(ADDR_W), .REG_ADDR(REG_A)) u_rcsr_top (
    .clk(clk), .pwr_on_rst(pwr_on_rst), .src_pin(src_pin), .src_wdog(src_wdog),
    .src_illop(src_illop), .src_illadr(src_illadr),
    .src_illadr_fetch(src_illadr_fetch), .src_lowv(src_lowv),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // vector: [19:16] req tag, [15:10] {pin,wdog,illop,illadr,fetch,lowv},
  // [9] rd_en, [8] addr is register, [7:0] expected rd_data this cycle
  localparam int NV = 19;
  localparam logic [19:0] VEC [NV] = '{
    {4'd1, 6'b000000, 1'b1, 1'b1, 8'h80},  // R1 power-on pattern, read clears
    {4'd5, 6'b000000, 1'b1, 1'b1, 8'h00},  // R5 cleared by prior read
    {4'd10,6'b100000, 1'b0, 1'b0, 8'h00},  // R10 pin pulse, idle bus
    {4'd3, 6'b000000, 1'b1, 1'b1, 8'h40},  // R3 pin flag bit 6 (R2)
    {4'd10,6'b010000, 1'b0, 1'b0, 8'h00},  // watchdog pulse
    {4'd6, 6'b000000, 1'b1, 1'b0, 8'h00},  // R6 other address
    {4'd6, 6'b000000, 1'b1, 1'b1, 8'h20},  // R6 flag survived, R3 bit 5
    {4'd10,6'b001000, 1'b0, 1'b0, 8'h00},  // illegal opcode
    {4'd10,6'b000001, 1'b0, 1'b0, 8'h00},  // low voltage
    {4'd7, 6'b000000, 1'b1, 1'b1, 8'h12},  // R7 accumulated bits 4 and 1
    {4'd10,6'b000100, 1'b0, 1'b0, 8'h00},  // illegal address, data access
    {4'd4, 6'b000000, 1'b1, 1'b1, 8'h00},  // R4 no flag without fetch
    {4'd10,6'b000110, 1'b0, 1'b0, 8'h00},  // illegal address fetch
    {4'd4, 6'b000000, 1'b1, 1'b1, 8'h08},  // R4 bit 3 set
    {4'd8, 6'b100000, 1'b1, 1'b1, 8'h00},  // R8 pin during clearing read
    {4'd8, 6'b000000, 1'b1, 1'b1, 8'h40},  // R8 new flag survived
    {4'd10,6'b111111, 1'b0, 1'b0, 8'h00},  // all sources
    {4'd9, 6'b000000, 1'b1, 1'b1, 8'h7A},  // R9 bits 2,0 zero; R2 layout
    {4'd5, 6'b000000, 1'b1, 1'b1, 8'h00}   // R5 cleared
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [5:0] s, input logic r, input logic here);
    {src_pin, src_wdog, src_illop, src_illadr, src_illadr_fetch, src_lowv} = s;
    rd_en   = r;
    rd_addr = here ? REG_A : OTHER_A;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    drive(6'b000000, 1'b1, 1'b1);
    #1 check("R1 reset state", rd_data, 8'h80);
    drive(6'b000000, 1'b0, 1'b1);
    #0 pwr_on_rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][15:10], VEC[i][9], VEC[i][8]);
      #1 check($sformatf("R%0d vec %0d", VEC[i][19:16], i), rd_data, VEC[i][7:0]);
    end

    // R1: power-on wins over an accumulated flag and a same-cycle source
    @(negedge clk); drive(6'b010000, 1'b0, 1'b0);
    @(negedge clk); drive(6'b100001, 1'b0, 1'b0); pwr_on_rst = 1'b1;
    @(negedge clk); drive(6'b000000, 1'b0, 1'b0); pwr_on_rst = 1'b0;
    @(negedge clk); drive(6'b000000, 1'b1, 1'b1);
    #1 check("R1 priority", rd_data, 8'h80);
    @(negedge clk); drive(6'b000000, 1'b1, 1'b1);
    #1 check("R5 after por read", rd_data, 8'h00);
    // R3: each remaining single source on its own
    @(negedge clk); drive(6'b001000, 1'b0, 1'b0);
    @(negedge clk); drive(6'b000000, 1'b1, 1'b1);
    #1 check("R3 illop alone", rd_data, 8'h10);
    @(negedge clk); drive(6'b000001, 1'b0, 1'b0);
    @(negedge clk); drive(6'b000000, 1'b1, 1'b0);
    #1 check("R6 other addr data", rd_data, 8'h00);
    @(negedge clk); drive(6'b000000, 1'b1, 1'b1);
    #1 check("R3 lowv alone", rd_data, 8'h02);
    @(negedge clk); drive(6'b000000, 1'b0, 1'b0);
    #1 check("R10 idle", rd_data, 8'h00);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule